// File: doc/BRIEF.md
# Register-File ALU Datapath

This block is a clocked datapath built around four 8-bit storage words. Two read ports, each a row of 4-to-1 multiplexers with its own 2-bit select, pick the two operands from the words. The operands drive an arithmetic and logic unit, and its 4-bit opcode chooses what it computes. The result returns to one word, chosen by a 2-bit destination code through a 1-of-4 decoder, on the rising clock edge while the write enable is high. One operation completes per clock.

A carry flag register stores the unit's carry-out on every write. The contents of all four words, the carry flag and the live ALU result are visible at the outputs. The words start from zero after reset. The host builds any value with the unit's own operations, for example clear, shift left and increment. All pins are plain control and status signals. No port carries a streamed data flow, so the block has no valid/ready handshake and applies no back-pressure.

Top module: `rfdp_core`

## Requirements
- R1: When `rst_i` is high at a rising edge, all four words and the carry flag become zero after that edge.
- R2: When `wr_en_i` is high at a rising edge, the word selected by `dst_sel_i` takes `result_o` and the other three words keep their values.
- R3: When `wr_en_i` is low at a rising edge, no word and not the carry flag changes, for any opcode or select values.
- R4: Select code k (0 to 3) on `src_a_sel_i` or `src_b_sel_i` reads word k, which sits at `regs_o[8k+7:8k]`. The two selects are independent and may name the same word.
- R5: Opcode 0 gives A AND B, opcode 1 gives A OR B, opcode 2 passes A and opcode 3 passes B. Each of these gives a carry-out of 0.
- R6: Opcode 4 gives the low 8 bits of A+B, and the carry-out is bit 8 of the sum.
- R7: Opcode 5 gives A-B modulo 256, and the carry-out is 1 exactly when A >= B (no borrow).
- R8: Opcode 6 gives A XOR B and opcode 7 gives NOT A. Both give a carry-out of 0.
- R9: Opcode 8 gives A+1, with carry-out 1 only when A is 0xFF. Opcode 9 gives A shifted left by one with a 0 fill, and the carry-out is the old bit 7 of A.
- R10: Opcodes 10 to 15 give a result of 0 and a carry-out of 0.
- R11: `carry_o` takes the ALU carry-out at every edge where a write occurs, and keeps its value at every other edge.
- R12: An operation whose destination is also one of its sources uses the value the word held before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all state changes on the rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| src_a_sel_i | input | 2 | Word feeding ALU operand A |
| src_b_sel_i | input | 2 | Word feeding ALU operand B |
| dst_sel_i | input | 2 | Word that receives the result |
| wr_en_i | input | 1 | Write the result and the carry at this edge |
| opcode_i | input | 4 | ALU operation code |
| regs_o | output | 32 | Word k at bits 8k+7 down to 8k |
| carry_o | output | 1 | Stored carry flag |
| result_o | output | 8 | Combinational ALU result for the current selects |

## Verification
The properties assume that every select, the opcode and the write enable are known values at each rising edge outside reset. The checks on one edge compare the state with the values from the previous edge, so they also assume that reset is not raised during an operation that is being checked. The bench changes every input only at the falling edge and always drives defined codes. It clears the write enable as soon as each operation finishes, and it raises reset only between scenarios.

// File: rtl/rfdp_pkg.sv
package rfdp_pkg;

  localparam int unsigned OPCODE_W = 4;

  typedef enum logic [OPCODE_W-1:0] {
    OP_AND    = 4'd0,
    OP_OR     = 4'd1,
    OP_PASS_A = 4'd2,
    OP_PASS_B = 4'd3,
    OP_ADD    = 4'd4,
    OP_SUB    = 4'd5,
    OP_XOR    = 4'd6,
    OP_NOT_A  = 4'd7,
    OP_INC_A  = 4'd8,
    OP_SHL_A  = 4'd9
  } alu_op_e;

endpackage

// File: rtl/rfdp_read_port.sv
module rfdp_read_port #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NUM_REGS = 4,
  localparam int unsigned SEL_W   = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] words_i,
  input  logic [SEL_W-1:0]                sel_i,
  output logic [DATA_W-1:0]               data_o
);

  // One NUM_REGS-to-1 multiplexer per bit, all sharing sel_i.
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    logic [NUM_REGS-1:0] column;
    for (genvar k = 0; k < NUM_REGS; k++) begin : g_word
      assign column[k] = words_i[k][b];
    end
    assign data_o[b] = column[sel_i];
  end

endmodule

// File: rtl/rfdp_wr_demux.sv
module rfdp_wr_demux #(
  parameter int unsigned NUM_REGS = 4,
  localparam int unsigned SEL_W   = $clog2(NUM_REGS)
) (
  input  logic                wr_en_i,
  input  logic [SEL_W-1:0]    dst_sel_i,
  output logic [NUM_REGS-1:0] load_o
);

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_load
    assign load_o[k] = wr_en_i && (dst_sel_i == SEL_W'(k));
  end

endmodule

// File: rtl/rfdp_regfile.sv
module rfdp_regfile #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NUM_REGS = 4
) (
  input  logic                            clk_i,
  input  logic                            rst_i,
  input  logic [NUM_REGS-1:0]             load_i,
  input  logic [DATA_W-1:0]               wdata_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0] words_o
);

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_word
    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        words_o[k] <= '0;
      end else if (load_i[k]) begin
        words_o[k] <= wdata_i;
      end
    end
  end

endmodule

// File: rtl/rfdp_alu.sv
module rfdp_alu
  import rfdp_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0]   a_i,
  input  logic [DATA_W-1:0]   b_i,
  input  logic [OPCODE_W-1:0] op_i,
  output logic [DATA_W-1:0]   result_o,
  output logic                carry_o
);

  localparam int unsigned WIDE_W = DATA_W + 1;

  logic [WIDE_W-1:0] wide;
  logic [WIDE_W-1:0] a_ext;
  logic [WIDE_W-1:0] b_ext;

  assign a_ext = {1'b0, a_i};
  assign b_ext = {1'b0, b_i};

  always_comb begin
    wide = '0;
    case (alu_op_e'(op_i))
      OP_AND:    wide = {1'b0, a_i & b_i};
      OP_OR:     wide = {1'b0, a_i | b_i};
      OP_PASS_A: wide = a_ext;
      OP_PASS_B: wide = b_ext;
      OP_ADD:    wide = a_ext + b_ext;
      OP_SUB:    wide = a_ext + {1'b0, ~b_i} + WIDE_W'(1);
      OP_XOR:    wide = {1'b0, a_i ^ b_i};
      OP_NOT_A:  wide = {1'b0, ~a_i};
      OP_INC_A:  wide = a_ext + WIDE_W'(1);
      OP_SHL_A:  wide = {a_i, 1'b0};
      default:   wide = '0;
    endcase
  end

  assign result_o = wide[DATA_W-1:0];
  assign carry_o  = wide[DATA_W];

endmodule

// File: rtl/rfdp_core.sv
module rfdp_core
  import rfdp_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NUM_REGS = 4,
  localparam int unsigned SEL_W   = $clog2(NUM_REGS),
  localparam int unsigned FLAT_W  = DATA_W * NUM_REGS
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic [SEL_W-1:0]    src_a_sel_i,
  input  logic [SEL_W-1:0]    src_b_sel_i,
  input  logic [SEL_W-1:0]    dst_sel_i,
  input  logic                wr_en_i,
  input  logic [OPCODE_W-1:0] opcode_i,
  output logic [FLAT_W-1:0]   regs_o,
  output logic                carry_o,
  output logic [DATA_W-1:0]   result_o
);

  logic [NUM_REGS-1:0][DATA_W-1:0] words;
  logic [NUM_REGS-1:0]             load;
  logic [DATA_W-1:0]               opnd_a;
  logic [DATA_W-1:0]               opnd_b;
  logic                            alu_carry;
  logic                            carry_q;

  rfdp_read_port #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) port_a_i (
    .words_i (words),
    .sel_i   (src_a_sel_i),
    .data_o  (opnd_a)
  );

  rfdp_read_port #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) port_b_i (
    .words_i (words),
    .sel_i   (src_b_sel_i),
    .data_o  (opnd_b)
  );

  rfdp_alu #(.DATA_W(DATA_W)) alu_i (
    .a_i      (opnd_a),
    .b_i      (opnd_b),
    .op_i     (opcode_i),
    .result_o (result_o),
    .carry_o  (alu_carry)
  );

  rfdp_wr_demux #(.NUM_REGS(NUM_REGS)) demux_i (
    .wr_en_i   (wr_en_i),
    .dst_sel_i (dst_sel_i),
    .load_o    (load)
  );

  rfdp_regfile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) regs_i (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .load_i  (load),
    .wdata_i (result_o),
    .words_o (words)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      carry_q <= 1'b0;
    end else if (wr_en_i) begin
      carry_q <= alu_carry;
    end
  end

  assign carry_o = carry_q;
  assign regs_o  = words;

endmodule

// File: rtl/rfdp_core_chk.sv
module rfdp_core_chk #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NUM_REGS = 4,
  localparam int unsigned SEL_W   = $clog2(NUM_REGS),
  localparam int unsigned FLAT_W  = DATA_W * NUM_REGS
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic [SEL_W-1:0]  src_a_sel_i,
  input logic [SEL_W-1:0]  dst_sel_i,
  input logic              wr_en_i,
  input logic [3:0]        opcode_i,
  input logic [FLAT_W-1:0] regs_o,
  input logic              carry_o,
  input logic [DATA_W-1:0] result_o,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b,
  input logic              alu_carry
);

  logic [DATA_W-1:0] w [NUM_REGS];
  logic              rst_seen_q = 1'b0;

  always_comb begin
    for (int k = 0; k < NUM_REGS; k++) begin
      w[k] = regs_o[k*DATA_W +: DATA_W];
    end
  end

  // R1: the edge after a reset edge shows cleared state
  always_ff @(posedge clk_i) begin
    if (rst_seen_q) begin
      a_r1_reset_clears: assert (regs_o == '0 && carry_o == 1'b0)
        else $error("reset did not clear state");
    end
    rst_seen_q <= rst_i;
  end

  // R2: destination word receives the result
  a_r2_dst_written: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_en_i |=> w[$past(dst_sel_i)] == $past(result_o));

  // R2: non-destination words stay, R3: nothing moves without a write
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_word
    a_r2_others_kept: assert property (@(posedge clk_i) disable iff (rst_i)
      (wr_en_i && dst_sel_i != SEL_W'(k)) |=> $stable(w[k]));
    a_r3_no_write_hold: assert property (@(posedge clk_i) disable iff (rst_i)
      !wr_en_i |=> $stable(w[k]));
  end

  // R4: port A delivers the selected word
  a_r4_port_a_select: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |-> opnd_a == w[src_a_sel_i]);

  // R6: addition matches a full-width sum of the port outputs
  a_r6_add_sum: assert property (@(posedge clk_i) disable iff (rst_i)
    opcode_i == 4'd4 |-> {alu_carry, result_o} == ({1'b0, opnd_a} + {1'b0, opnd_b}));

  // R10: reserved codes produce zero
  a_r10_reserved_zero: assert property (@(posedge clk_i) disable iff (rst_i)
    opcode_i >= 4'd10 |-> (result_o == '0 && !alu_carry));

  // R11: flag follows carry on writes, holds otherwise
  a_r11_carry_capture: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_en_i |=> carry_o == $past(alu_carry));
  a_r11_carry_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    !wr_en_i |=> $stable(carry_o));

endmodule

bind rfdp_core rfdp_core_chk #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) chk_i (
  .clk_i       (clk_i),
  .rst_i       (rst_i),
  .src_a_sel_i (src_a_sel_i),
  .dst_sel_i   (dst_sel_i),
  .wr_en_i     (wr_en_i),
  .opcode_i    (opcode_i),
  .regs_o      (regs_o),
  .carry_o     (carry_o),
  .result_o    (result_o),
  .opnd_a      (opnd_a),
  .opnd_b      (opnd_b),
  .alu_carry   (alu_carry)
);

// File: tb/rfdp_core_tb_top.sv
`timescale 1ns/1ps
module rfdp_core_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  sa, sb, sd;
  logic        we;
  logic [3:0]  op;
  logic [31:0] regs;
  logic        carry;
  logic [7:0]  result;

  int checks = 0;
  int errors = 0;

  logic [7:0] m [4];
  logic       mc;

  always #2.5 clk = ~clk;

  rfdp_core dut_i (
    .clk_i       (clk),
    .rst_i       (rst),
    .src_a_sel_i (sa),
    .src_b_sel_i (sb),
    .dst_sel_i   (sd),
    .wr_en_i     (we),
    .opcode_i    (op),
    .regs_o      (regs),
    .carry_o     (carry),
    .result_o    (result)
  );

  function automatic logic [8:0] model(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b);
    case (o)
      4'd0: return {1'b0, a & b};
      4'd1: return {1'b0, a | b};
      4'd2: return {1'b0, a};
      4'd3: return {1'b0, b};
      4'd4: return {1'b0, a} + {1'b0, b};
      4'd5: return {(a >= b), 8'(a - b)};
      4'd6: return {1'b0, a ^ b};
      4'd7: return {1'b0, ~a};
      4'd8: return {(a == 8'hFF), 8'(a + 8'd1)};
      4'd9: return {a[7], a[6:0], 1'b0};
      default: return 9'd0;
    endcase
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_state(input string tag);
    for (int k = 0; k < 4; k++) begin
      chk(regs[k*8 +: 8] == m[k], tag, 32'(regs[k*8 +: 8]), 32'(m[k]));
    end
    chk(carry == mc, "R11", 32'(carry), 32'(mc));
  endtask

  // Drive one operation at a falling edge, check the live result,
  // let the rising edge act, then check the state.
  task automatic do_op(input logic [3:0] o, input int a, input int b, input int d,
                       input logic w, input string tag);
    logic [8:0] exp;
    @(negedge clk);
    op = o; sa = 2'(a); sb = 2'(b); sd = 2'(d); we = w;
    #1;
    exp = model(o, m[a], m[b]);
    chk(result == exp[7:0], tag, 32'(result), 32'(exp[7:0]));
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
    if (w) begin
      m[d] = exp[7:0];
      mc = exp[8];
      chk_state("R2");
    end else begin
      chk_state("R3");
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; we = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 4; k++) m[k] = 8'h00;
    mc = 1'b0;
    chk_state("R1");
  endtask

  task automatic load_word(input int d, input logic [7:0] v);
    do_op(4'd6, d, d, d, 1'b1, "R8");
    for (int i = 7; i >= 0; i--) begin
      do_op(4'd9, d, d, d, 1'b1, "R9");
      if (v[i]) do_op(4'd8, d, d, d, 1'b1, "R9");
    end
  endtask

  task automatic t_load();
    load_word(0, 8'hA5);
    load_word(1, 8'h3C);
    load_word(2, 8'hFF);
    load_word(3, 8'h01);
  endtask

  task automatic t_selects();
    for (int k = 0; k < 4; k++) begin
      do_op(4'd2, k, 3 - k, 0, 1'b0, "R4");
      do_op(4'd3, 3 - k, k, 0, 1'b0, "R4");
    end
    do_op(4'd6, 1, 1, 0, 1'b0, "R4");
  endtask

  task automatic t_logic();
    do_op(4'd0, 0, 1, 3, 1'b1, "R5");
    do_op(4'd1, 0, 1, 3, 1'b1, "R5");
    do_op(4'd2, 1, 0, 3, 1'b1, "R5");
    do_op(4'd3, 1, 0, 3, 1'b1, "R5");
    do_op(4'd6, 0, 1, 3, 1'b1, "R8");
    do_op(4'd7, 0, 1, 3, 1'b1, "R8");
  endtask

  task automatic t_arith();
    load_word(3, 8'h01);
    do_op(4'd4, 2, 3, 3, 1'b1, "R6");
    do_op(4'd4, 1, 1, 3, 1'b1, "R6");
    do_op(4'd4, 2, 2, 3, 1'b1, "R6");
    do_op(4'd5, 0, 0, 3, 1'b1, "R7");
    do_op(4'd5, 1, 0, 3, 1'b1, "R7");
    do_op(4'd5, 0, 1, 3, 1'b1, "R7");
    do_op(4'd8, 2, 2, 3, 1'b1, "R9");
    do_op(4'd9, 0, 0, 3, 1'b1, "R9");
  endtask

  task automatic t_hold();
    do_op(4'd4, 2, 2, 3, 1'b1, "R6");
    for (int o = 0; o < 16; o++) begin
      do_op(4'(o), o % 4, (o + 1) % 4, o % 4, 1'b0, "R3");
    end
  endtask

  task automatic t_self();
    do_op(4'd4, 1, 1, 1, 1'b1, "R12");
    do_op(4'd5, 0, 2, 2, 1'b1, "R12");
    do_op(4'd7, 0, 0, 0, 1'b1, "R12");
  endtask

  task automatic t_reserved();
    do_op(4'd4, 2, 2, 1, 1'b1, "R6");
    for (int o = 10; o < 16; o++) begin
      load_word(1, 8'hC3);
      do_op(4'(o), 0, 2, 1, 1'b1, "R10");
    end
  endtask

  initial begin
    rst = 1'b1; we = 1'b0; op = '0; sa = '0; sb = '0; sd = '0;
    for (int k = 0; k < 4; k++) m[k] = 8'h00;
    mc = 1'b0;
    t_reset();
    t_load();
    t_selects();
    t_logic();
    t_arith();
    t_hold();
    t_self();
    t_reserved();
    t_load();
    t_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #900000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule